// File: doc/BRIEF.md
# Dual-Strobe Synchronous SRAM Access Controller

This block is the control front end of a small synchronous single-port SRAM with a shared data bus. On every rising clock edge it samples three chip selects, two competing address strobes (one for a processor, one for a controller), a set of active-low write controls and an adjusting input for the burst counter. From these it decides whether an access begins, loads the address register, performs byte-lane writes into an internal memory, and produces registered read data. The bus is modelled as separate input data, output data and an output-enable. Its output-enable follows the asynchronous, active-low output enable input and is forced off whenever the write controls call for a write.

The two strobes differ in write timing. A controller-strobe start writes in the same edge when the write controls ask for it, and otherwise it is a read. A processor-strobe start ignores the write controls at the start edge, and its write data is taken at the following edge. The processor strobe only counts while the first chip select is low. The controller strobe is masked whenever the processor strobe is low. The burst counter itself lives elsewhere; this block only signals when it should load and when it should step.

Top module: `dual_strobe_sram_ctrl`

## Requirements
- R1: An access starts at an edge where `sel1_n` is low, `sel2` is high, `sel3_n` is low and either `pstrb_n` or `cstrb_n` is low; during that cycle `addr_load` is high and after the edge `acc_addr` equals the sampled `addr`.
- R2: With `sel1_n` high, a low `pstrb_n` (and `cstrb_n` high) has no effect: no load and no change to an open access, which keeps reading its held address.
- R3: While `pstrb_n` is low the controller strobe is ignored, so a start with both strobes low behaves as a processor start and writes nothing at the start edge.
- R4: After a processor start the write controls at the start edge are ignored; if they call for a write at the next edge (with no new start), `dq_in` is written to the held address.
- R5: A controller start whose write controls call for a write stores `dq_in` at `addr` on that same edge; without a write request it is a read.
- R6: With `gw_n` low, a write updates both lanes (bits 15:8 and 7:0), whatever `bwe_n` and `bsel_n` hold.
- R7: With `gw_n` high, a write needs `bwe_n` low; `bsel_n[0]` low enables bits 7:0 and `bsel_n[1]` low enables bits 15:8; with `bwe_n` high nothing is written.
- R8: `dq_oe` is low whenever a write is requested (`gw_n` low, or `bwe_n` low with any `bsel_n` bit low), even while `oe_n` is low.
- R9: One edge after the address is held by an open access with no write, `dq_out` carries the stored word and `dq_oe` equals `!oe_n` combinationally.
- R10: A deselect (a counted strobe low while the chip selects are not all active) closes the access; afterwards reads stop, `dq_oe` stays low and write controls write nothing.
- R11: `burst_adv` is high in a cycle where an access is open, no start or deselect occurs and `adv_n` is low; it is low in a start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel1_n | input | 1 | First chip select, active low; also gates the processor strobe |
| sel2 | input | 1 | Second chip select, active high |
| sel3_n | input | 1 | Third chip select, active low |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance request, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | 2 | Per-lane byte selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 4 | Word address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Registered read data to the bus |
| dq_oe | output | 1 | Bus drive enable |
| addr_load | output | 1 | Burst counter load request (start in this cycle) |
| burst_adv | output | 1 | Burst counter step request |
| acc_addr | output | 4 | Address held for the open access |

## Verification
A wrong held address or a wrongly closed access shows at the ports one edge later, as read data from the wrong word or as `dq_oe` staying low while `oe_n` is low. A write taken on the wrong edge or on the wrong lanes is invisible at once and only appears when that word is read back, so every word is written through both strobe paths over all sixteen write-control patterns and then read back against a bench-side model. The bus enable is combinational, so errors in its gating by `oe_n` or by the write controls appear within the same cycle.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    // Which strobe, if any, opened an access on this edge.
    typedef enum logic [1:0] {
        ST_NONE = 2'd0,
        ST_PROC = 2'd1,
        ST_CTRL = 2'd2
    } start_kind_e;

endpackage

// File: rtl/dsc_strobe_decode.sv
module dsc_strobe_decode
    import dsc_pkg::*;
(
    input  logic        sel1_n,
    input  logic        sel2,
    input  logic        sel3_n,
    input  logic        pstrb_n,
    input  logic        cstrb_n,
    output start_kind_e kind,
    output logic        desel
);

    logic chips_on;
    logic p_eff;
    logic c_eff;

    always_comb begin
        chips_on = !sel1_n && sel2 && !sel3_n;
        // processor strobe is only seen while the first select is low
        p_eff    = !pstrb_n && !sel1_n;
        // controller strobe is masked by any low processor strobe
        c_eff    = !cstrb_n && pstrb_n;

        kind = ST_NONE;
        if (chips_on && p_eff) begin
            kind = ST_PROC;
        end else if (chips_on && c_eff) begin
            kind = ST_CTRL;
        end

        desel = !chips_on && (p_eff || !cstrb_n);
    end

endmodule

// File: rtl/dsc_write_decode.sv
module dsc_write_decode #(
    parameter int LANES = 2
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    output logic [LANES-1:0] lane_mask,
    output logic             wr_req
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            lane_mask[g] = !gw_n || (!bwe_n && !bsel_n[g]);
        end
    end

    always_comb begin
        wr_req = |lane_mask;
    end

endmodule

// File: rtl/dsc_data_store.sv
module dsc_data_store #(
    parameter int AW    = 4,
    parameter int LANES = 2,
    parameter int LW    = 8,
    localparam int DEPTH = 1 << AW,
    localparam int DW    = LANES * LW
) (
    input  logic             clk,
    input  logic [LANES-1:0] we,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] mem_q [DEPTH];
        logic [LW-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we[g]) begin
                mem_q[waddr] <= wdata[g*LW +: LW];
            end
            if (re) begin
                rd_q <= mem_q[raddr];
            end
        end

        always_comb begin
            rdata[g*LW +: LW] = rd_q;
        end
    end

endmodule

// File: rtl/dual_strobe_sram_ctrl.sv
module dual_strobe_sram_ctrl
    import dsc_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 2,
    parameter int LW    = 8,
    localparam int DW   = LANES * LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel1_n,
    input  logic             sel2,
    input  logic             sel3_n,
    input  logic             pstrb_n,
    input  logic             cstrb_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    input  logic             oe_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    dq_in,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe,
    output logic             addr_load,
    output logic             burst_adv,
    output logic [AW-1:0]    acc_addr
);

    typedef struct packed {
        logic          open;
        logic          rd_valid;
        logic [AW-1:0] addr;
    } ctl_t;

    ctl_t s_d, s_q;

    start_kind_e      kind;
    logic             desel;
    logic [LANES-1:0] lane_mask;
    logic             wr_req;
    logic             wr_en;
    logic             rd_en;
    logic             start;
    logic [LANES-1:0] lane_we;
    logic [AW-1:0]    waddr;

    dsc_strobe_decode u_strobe (
        .sel1_n  (sel1_n),
        .sel2    (sel2),
        .sel3_n  (sel3_n),
        .pstrb_n (pstrb_n),
        .cstrb_n (cstrb_n),
        .kind    (kind),
        .desel   (desel)
    );

    dsc_write_decode #(.LANES(LANES)) u_wdec (
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .bsel_n    (bsel_n),
        .lane_mask (lane_mask),
        .wr_req    (wr_req)
    );

    always_comb begin
        s_d   = s_q;
        start = (kind != ST_NONE);
        // controller start writes at once; an open access writes on later edges
        wr_en = (kind == ST_CTRL && wr_req)
             || (s_q.open && kind == ST_NONE && !desel && wr_req);
        waddr = (kind == ST_CTRL) ? addr : s_q.addr;
        lane_we = wr_en ? lane_mask : '0;
        rd_en = s_q.open && !wr_en && !desel;

        s_d.rd_valid = rd_en;
        if (start) begin
            s_d.open = 1'b1;
            s_d.addr = addr;
        end else if (desel) begin
            s_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    dsc_data_store #(.AW(AW), .LANES(LANES), .LW(LW)) u_store (
        .clk   (clk),
        .we    (lane_we),
        .waddr (waddr),
        .wdata (dq_in),
        .re    (rd_en),
        .raddr (s_q.addr),
        .rdata (dq_out)
    );

    always_comb begin
        dq_oe     = !oe_n && s_q.rd_valid && !wr_req;
        addr_load = start;
        burst_adv = s_q.open && !start && !desel && !adv_n;
        acc_addr  = s_q.addr;
    end

    // R1: a start loads the held address
    p_addr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ST_NONE) |=> (s_q.addr == $past(addr)));

    // R3: a low processor strobe always wins the start
    p_cstrb_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstrb_n && kind != ST_NONE) |-> (kind == ST_PROC));

    // R4: nothing is written on a processor start edge
    p_proc_start_nowr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ST_PROC) |-> (lane_we == '0));

    // R6: a global write reaches every lane
    p_gw_all_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !gw_n) |-> (&lane_we));

    // R8: the bus is never driven while a write is requested
    p_bus_off_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gw_n) |-> !dq_oe);

    // R9: read data only follows a cycle with an open access
    p_read_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rd_valid |-> $past(s_q.open));

    // R10: a deselect with no start closes the access
    p_desel_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (desel && kind == ST_NONE) |=> !s_q.open);

endmodule

// File: tb/dual_strobe_sram_ctrl_tb.sv
module dual_strobe_sram_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel1_n, sel2, sel3_n, pstrb_n, cstrb_n, adv_n;
    logic        gw_n, bwe_n, oe_n;
    logic [1:0]  bsel_n;
    logic [3:0]  addr;
    logic [15:0] dq_in;
    logic [15:0] dq_out;
    logic        dq_oe, addr_load, burst_adv;
    logic [3:0]  acc_addr;

    int total = 0;
    int bad   = 0;
    logic [15:0] ref_mem [16];

    always #5 clk = ~clk;

    dual_strobe_sram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .addr_load(addr_load),
        .burst_adv(burst_adv), .acc_addr(acc_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        sel1_n = 1; sel2 = 0; sel3_n = 1; pstrb_n = 1; cstrb_n = 1;
        gw_n = 1; bwe_n = 1; bsel_n = 2'b11; adv_n = 1; oe_n = 1;
    endtask

    task automatic chips();
        sel1_n = 0; sel2 = 1; sel3_n = 0;
    endtask

    task automatic close_acc();
        idle();
        cstrb_n = 0;
        step();
        idle();
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic gw, input logic bwe,
                                          input logic [1:0] bs);
        logic [15:0] r;
        r = old;
        if (!gw) r = d;
        else if (!bwe) begin
            if (!bs[0]) r[7:0]  = d[7:0];
            if (!bs[1]) r[15:8] = d[15:8];
        end
        return r;
    endfunction

    // controller start; write on the start edge if requested, then read back
    task automatic c_access(input logic [3:0] a, input logic [15:0] d, input logic gw,
                            input logic bwe, input logic [1:0] bs);
        idle(); chips(); cstrb_n = 0; addr = a; dq_in = d;
        gw_n = gw; bwe_n = bwe; bsel_n = bs;
        #1 chk(addr_load == 1'b1, "R1 load on controller start", addr_load, 1);
        step();
        ref_mem[a] = merge(ref_mem[a], d, gw, bwe, bs);
        chk(acc_addr == a, "R1 held address", acc_addr, a);
        idle(); oe_n = 0;
        step();
        chk(dq_oe == 1'b1, "R9 bus enabled", dq_oe, 1);
        chk(dq_out == ref_mem[a], "R5 R6 R7 controller word", dq_out, ref_mem[a]);
        close_acc();
    endtask

    // processor start with junk write request at start, real write next edge
    task automatic p_write(input logic [3:0] a, input logic [15:0] d, input logic gw,
                           input logic bwe, input logic [1:0] bs);
        idle(); chips(); pstrb_n = 0; addr = a; gw_n = 0; dq_in = ~d;
        step();
        idle(); gw_n = gw; bwe_n = bwe; bsel_n = bs; dq_in = d; addr = ~a;
        step();
        ref_mem[a] = merge(ref_mem[a], d, gw, bwe, bs);
        idle(); oe_n = 0;
        step();
        chk(dq_out == ref_mem[a], "R4 R6 R7 processor word", dq_out, ref_mem[a]);
        close_acc();
    endtask

    // processor start (optionally with controller strobe low too) and read
    task automatic p_read(input logic [3:0] a, input bit both);
        idle(); chips(); pstrb_n = 0; cstrb_n = both ? 1'b0 : 1'b1; addr = a;
        gw_n = 0; dq_in = 16'hDEAD; adv_n = 0;
        #1 chk(burst_adv == 1'b0, "R11 no step on start", burst_adv, 0);
        step();
        idle(); oe_n = 0; adv_n = 0;
        #1 chk(burst_adv == 1'b1, "R11 step request", burst_adv, 1);
        step();
        chk(dq_oe == 1'b1, "R9 bus enabled after read", dq_oe, 1);
        if (both) chk(dq_out == ref_mem[a], "R3 controller masked", dq_out, ref_mem[a]);
        else      chk(dq_out == ref_mem[a], "R4 start write ignored", dq_out, ref_mem[a]);
        oe_n = 1;
        #1 chk(dq_oe == 1'b0, "R9 async oe off", dq_oe, 0);
        oe_n = 0; bwe_n = 0; bsel_n = 2'b10;
        #1 chk(dq_oe == 1'b0, "R8 bus off on byte write", dq_oe, 1'b0);
        bwe_n = 1; bsel_n = 2'b11;
        #1 chk(dq_oe == 1'b1, "R9 async oe on", dq_oe, 1);
        close_acc();
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(); addr = 0; dq_in = 0; rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        oe_n = 0;
        #1 chk(dq_oe == 1'b0, "reset bus off", dq_oe, 0);
        chk(addr_load == 1'b0, "reset no load", addr_load, 0);
        chk(acc_addr == 4'd0, "reset address", acc_addr, 0);
        idle();

        // fill every word with a global write via the controller strobe
        for (int a = 0; a < 16; a++) begin
            ref_mem[a] = 16'h0;
            c_access(4'(a), 16'(16'h1111 * a) ^ 16'hA5C3, 1'b0, 1'b1, 2'b11);
        end

        // all 16 write-control patterns through both strobe paths
        for (int a = 0; a < 16; a++) begin
            logic [3:0] c;
            c = 4'(a);
            c_access(4'(a), 16'h3C00 + 16'(a * 37), c[3], c[2], c[1:0]);
            p_write(4'(15 - a), 16'h0F5A ^ 16'(a * 291), c[3], c[2], c[1:0]);
        end

        for (int a = 0; a < 16; a++) p_read(4'(a), a[0]);

        // R2: processor strobe with first select high is ignored
        idle(); chips(); pstrb_n = 0; addr = 4'd3;
        step();
        idle(); oe_n = 0; sel2 = 1; sel3_n = 0; pstrb_n = 0; addr = 4'd9;
        #1 chk(addr_load == 1'b0, "R2 no load", addr_load, 0);
        step();
        chk(acc_addr == 4'd3, "R2 address kept", acc_addr, 3);
        chk(dq_oe == 1'b1, "R2 access still open", dq_oe, 1);
        chk(dq_out == ref_mem[3], "R2 data of held word", dq_out, ref_mem[3]);
        close_acc();

        // R10: after deselect nothing is read or written
        idle(); oe_n = 0; gw_n = 0; dq_in = 16'hBEEF;
        step();
        gw_n = 1;
        #1 chk(dq_oe == 1'b0, "R10 bus quiet after deselect", dq_oe, 0);
        idle();
        p_read(4'd5, 1'b0);
        p_read(acc_addr, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule